// File: doc/BRIEF.md
# Frame writeback capture controller

This block takes pixel words from an upstream compositor stream and writes one whole frame into memory, one line after another. Each word becomes a memory write request. Its address is the start of its line plus the word's position in that line. Software sets up a destination base, a line pitch and the frame size through a small register file, then starts the frame through the control word. The status bit and a level interrupt show when the block has gone idle again.

Pixel words pass straight through to the memory request port. A word is taken only when memory grants it, so the upstream stream is throttled by the memory side. A progress register counts the lines whose last word has been granted. The frame ends when that count reaches the programmed height. Software can abort a frame at any time. A power-down bit keeps the block from starting a frame.

Top module: `fb_capture_ctrl`

Register map (byte offsets on `reg_addr`):
- 0x00 base: destination base address.
- 0x04 pitch: line pitch in bytes.
- 0x08 size: frame height in bits 31:16, width in words in bits 15:0.
- 0x0c control and status.
- 0x10 progress: committed line count, read only.

## Requirements
- R1: After reset the busy bit, the interrupt enable, the power-down bit, the progress count, `irq` and `mw_req` are all 0.
- R2: Reading the control register at 0x0c returns 0x54 in bits 31:24, binary 01 in bits 23:22, the power-down bit in bit 21, the interrupt enable in bit 2 and the busy bit in bit 1. Every other bit reads 0, including the start bit 0.
- R3: A control write with bit 0 set, while the block is idle, starts a frame when the written bit 21 and bit 14 are both 0 and width and height are both nonzero. In the next cycle busy reads 1 and progress reads 0.
- R4: A start request whose written word has bit 21 (power-down) set is ignored, and busy stays 0.
- R5: The address of word c of line n is (base with bits 1:0 cleared) + n × (pitch with bits 3:0 cleared) + 4·c. The cleared low bits also read back as 0.
- R6: `mw_req` equals busy AND `px_valid`, `px_ready` equals busy AND `mw_gnt`, and `mw_data` carries `px_data`. A word moves when `mw_req` and `mw_gnt` are both high.
- R7: Progress goes up by one in the cycle after the last word of a line (word width−1) moves.
- R8: When the word that completes line height−1 moves, busy reads 0 in the next cycle and progress equals the height.
- R9: `irq` is high exactly when the interrupt enable (control bit 2) is 1 and the block is idle. Writing bit 2 as 0 clears it.
- R10: A control write with bit 14 set drops busy in the next cycle and stops all further memory requests. Progress keeps the value it had.
- R11: A start request is ignored when the programmed width or height is 0.
- R12: A start request while busy is ignored. The running frame goes on without its progress or address being reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| px_valid | input | 1 | Upstream pixel word valid |
| px_data | input | DW | Upstream pixel word |
| px_ready | output | 1 | Pixel word accepted |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | 32 | Memory write byte address |
| mw_data | output | DW | Memory write data |
| mw_gnt | input | 1 | Memory write grant |
| irq | output | 1 | Idle interrupt (level) |

## Verification
The bench uses random valid and grant patterns, so stalls land on the last word of a line and on the last line of the frame. A design that bumped progress on a request rather than on a grant would then run ahead of memory. Misaligned base and pitch values are written, which catches a design that keeps their low bits and writes to misaligned addresses. An abort is issued in the middle of a frame, which catches a late-dropping busy bit and requests that go on after the abort. A repeated start during a frame is also issued; a design that restarts on it would rewrite lines already done. Start requests with power-down set or with a zero size are also tried; a design that accepts them would leave busy set for good or begin a frame it must not.

// File: rtl/fb_capture_ctrl.sv
module fb_capture_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          px_valid,
  input  logic [DW-1:0] px_data,
  output logic          px_ready,
  output logic          mw_req,
  output logic [31:0]   mw_addr,
  output logic [DW-1:0] mw_data,
  input  logic          mw_gnt,
  output logic          irq
);
  localparam int BPW = DW / 8;
  localparam int BSH = $clog2(BPW);
  localparam logic [4:0] A_BASE = 5'h00, A_PITCH = 5'h04, A_SIZE = 5'h08,
                         A_CTRL = 5'h0c, A_PROG = 5'h10;

  logic [31:0] base_q, pitch_q, line_q;
  logic [15:0] width_q, height_q, col_q, prog_q;
  logic        ei_q, pd_q, busy_q;

  logic we_ctrl, abort_w, go_w, xfer, eol, eof;
  assign we_ctrl = reg_we && reg_addr == A_CTRL;
  assign abort_w = we_ctrl && reg_wdata[14];
  assign go_w    = we_ctrl && reg_wdata[0] && !reg_wdata[14] && !reg_wdata[21]
                   && !busy_q && width_q != '0 && height_q != '0;
  assign xfer    = mw_req && mw_gnt;
  assign eol     = xfer && col_q == width_q - 16'd1;
  assign eof     = eol && prog_q == height_q - 16'd1;

  assign mw_req   = busy_q && px_valid;
  assign px_ready = busy_q && mw_gnt;
  assign mw_data  = px_data;
  assign mw_addr  = line_q + ({16'b0, col_q} << BSH);
  assign irq      = ei_q && !busy_q;

  always_comb begin
    case (reg_addr)
      A_BASE:  reg_rdata = base_q;
      A_PITCH: reg_rdata = pitch_q;
      A_SIZE:  reg_rdata = {height_q, width_q};
      A_CTRL:  reg_rdata = {8'h54, 2'b01, pd_q, 18'b0, ei_q, busy_q, 1'b0};
      A_PROG:  reg_rdata = {16'b0, prog_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; pitch_q <= '0; width_q <= '0; height_q <= '0;
      ei_q <= 1'b0; pd_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_BASE:  base_q  <= {reg_wdata[31:2], 2'b00};
        A_PITCH: pitch_q <= {reg_wdata[31:4], 4'b0000};
        A_SIZE:  {height_q, width_q} <= reg_wdata;
        A_CTRL:  begin ei_q <= reg_wdata[2]; pd_q <= reg_wdata[21]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; col_q <= '0; prog_q <= '0; line_q <= '0;
    end else if (go_w) begin
      busy_q <= 1'b1; col_q <= '0; prog_q <= '0; line_q <= base_q;
    end else begin
      if (xfer) begin
        if (eol) begin
          col_q  <= '0;
          prog_q <= prog_q + 16'd1;
          line_q <= line_q + pitch_q;
        end else begin
          col_q <= col_q + 16'd1;
        end
      end
      if (abort_w || eof) busy_q <= 1'b0;
    end
  end

  p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!busy_q && !mw_req));
  p_pd_blocks_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ctrl && reg_wdata[21] && !busy_q) |=> !busy_q);
  p_prog_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> prog_q == 16'd0);
  p_prog_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (prog_q == $past(prog_q) || prog_q == $past(prog_q) + 16'd1));
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy_q);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !go_w) |=> (!busy_q && prog_q == $past(height_q)));
endmodule

// File: tb/tb_fb_capture_ctrl.sv
module tb_fb_capture_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        px_valid = 0, px_ready, mw_req, mw_gnt = 0, irq;
  logic [31:0] px_data = 0, mw_addr, mw_data;
  int total = 0, bad = 0, cyc = 0;
  bit rnd_on = 0;

  always #4 clk = ~clk;

  fb_capture_ctrl #(.DW(32)) dut (.*);

  // behavioural reference state
  bit m_busy, m_ei, m_pd;
  logic [31:0] m_base, m_pitch;
  int m_w, m_h, m_prog, m_col, m_line;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_ei = 0; m_pd = 0; m_base = 0; m_pitch = 0;
      m_w = 0; m_h = 0; m_prog = 0; m_col = 0; m_line = 0;
    end else begin
      bit go, ab;
      go = reg_we && reg_addr == 5'h0c && reg_wdata[0] && !reg_wdata[14]
           && !reg_wdata[21] && !m_busy && m_w != 0 && m_h != 0;
      ab = reg_we && reg_addr == 5'h0c && reg_wdata[14];
      if (m_busy && px_valid && mw_gnt) begin
        if (m_col == m_w - 1) begin
          m_col = 0; m_line++; m_prog++;
          if (m_prog == m_h) m_busy = 0;
        end else m_col++;
      end
      if (ab) m_busy = 0;
      if (go) begin m_busy = 1; m_prog = 0; m_col = 0; m_line = 0; end
      if (reg_we) case (reg_addr)
        5'h00: m_base = reg_wdata & ~32'h3;
        5'h04: m_pitch = reg_wdata & ~32'hf;
        5'h08: begin m_w = int'(reg_wdata[15:0]); m_h = int'(reg_wdata[31:16]); end
        5'h0c: begin m_ei = reg_wdata[2]; m_pd = reg_wdata[21]; end
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] exp_rd();
    case (reg_addr)
      5'h00: return m_base;
      5'h04: return m_pitch;
      5'h08: return {m_h[15:0], m_w[15:0]};
      5'h0c: return 32'h5440_0000 | (32'(m_pd) << 21) | (32'(m_ei) << 2) | (32'(m_busy) << 1);
      5'h10: return 32'(m_prog);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    logic [31:0] ea;
    ea = m_base + 32'(m_line) * m_pitch + 32'(m_col) * 4;
    chk("R6 mw_req", 32'(mw_req), 32'(m_busy && px_valid));
    chk("R6 px_ready", 32'(px_ready), 32'(m_busy && mw_gnt));
    if (mw_req) begin
      chk("R5 mw_addr", mw_addr, ea);
      chk("R6 mw_data", mw_data, px_data);
    end
    chk("R9 irq", 32'(irq), 32'(m_ei && !m_busy));
    chk("R2 reg_rdata", reg_rdata, exp_rd());
  end

  always @(posedge clk) begin
    #2;
    if (rnd_on) begin
      px_valid = ($urandom % 4) != 0;
      mw_gnt   = ($urandom % 3) != 0;
      px_data  = $urandom;
    end else begin
      px_valid = 0; mw_gnt = 0;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2; reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #3; rd(5'h0c, d);
      if (!d[1]) break;
    end
  endtask

  initial begin : watchdog
    wait (cyc > 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #3;
    // R1 / R2 reset state
    rd(5'h0c, d); chk("R1 R2 ctrl after reset", d, 32'h5440_0000);
    rd(5'h10, d); chk("R1 progress after reset", d, 0);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 mw_req after reset", 32'(mw_req), 0);

    // R5 masking, R3 start, R7/R8 full frame
    wr(5'h00, 32'h0000_1003);
    wr(5'h04, 32'h0000_0047);
    rd(5'h00, d); chk("R5 base low bits", d, 32'h0000_1000);
    rd(5'h04, d); chk("R5 pitch low bits", d, 32'h0000_0040);
    wr(5'h08, {16'd4, 16'd3});
    wr(5'h0c, 32'h0000_0005);
    rd(5'h0c, d); chk("R3 busy after start", 32'(d[1]), 1);
    rd(5'h10, d); chk("R3 progress cleared", d, 0);
    chk("R9 irq low while busy", 32'(irq), 0);
    rnd_on = 1;
    wait_idle();
    rd(5'h10, d); chk("R8 progress equals height", d, 4);
    chk("R9 irq on idle", 32'(irq), 1);
    wr(5'h0c, 32'h0);
    chk("R9 irq acknowledged", 32'(irq), 0);

    // R4 power-down blocks start
    rnd_on = 0;
    wr(5'h0c, 32'h0020_0001);
    rd(5'h0c, d); chk("R4 busy stays low", 32'(d[1]), 0);
    chk("R4 pd bit readback", 32'(d[21]), 1);
    wr(5'h0c, 32'h0);

    // R11 zero height
    wr(5'h08, {16'd0, 16'd5});
    wr(5'h0c, 32'h1);
    rd(5'h0c, d); chk("R11 zero height ignored", 32'(d[1]), 0);
    wr(5'h08, {16'd6, 16'd0});
    wr(5'h0c, 32'h1);
    rd(5'h0c, d); chk("R11 zero width ignored", 32'(d[1]), 0);

    // R12 start while busy, then R10 abort
    wr(5'h00, 32'h0008_0000);
    wr(5'h04, 32'h0000_0100);
    wr(5'h08, {16'd40, 16'd5});
    wr(5'h0c, 32'h1);
    rnd_on = 1;
    repeat (30) @(posedge clk);
    #3; rd(5'h10, d);
    begin
      logic [31:0] p0, p1;
      p0 = d;
      wr(5'h0c, 32'h1);
      rd(5'h10, p1);
      chk("R12 restart ignored", 32'(p1 >= p0), 1);
      rd(5'h0c, d); chk("R12 still busy", 32'(d[1]), 1);
      repeat (20) @(posedge clk);
      #3; rd(5'h10, p0);
      wr(5'h0c, 32'h4000);
      rd(5'h0c, d); chk("R10 busy falls after abort", 32'(d[1]), 0);
      chk("R10 no request after abort", 32'(mw_req), 0);
      rd(5'h10, p1);
      chk("R10 progress held", 32'(p1 >= p0 && p1 < 40), 1);
      repeat (10) begin
        @(negedge clk); chk("R10 requests stay off", 32'(mw_req), 0);
      end
    end

    // second full frame with single-word lines
    wr(5'h08, {16'd7, 16'd1});
    wr(5'h0c, 32'h5);
    wait_idle();
    rd(5'h10, d); chk("R7 R8 one-word lines", d, 7);
    rnd_on = 0;
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule